// File: doc/BRIEF.md
# Data Cache Load Miss Tracker

This block keeps account of load misses that are waiting on the level-one data cache. A lookup arrives each cycle with a line address (the load address with its 5-bit byte offset removed, since a line is 32 bytes made of eight 32-bit words), a hit or miss result from the tag compare, and a destination tag naming the register that waits for the data. Every accepted miss takes a slot in a small miss queue. A miss to a line that no fill buffer holds also takes a fill buffer, and that buffer requests the whole line from the bus. A miss to a line that a fill buffer already holds joins that buffer and adds no bus traffic.

Bus read requests leave in the order their fill buffers were taken, through a valid/ready handshake that carries the line address and the fill buffer index. When the bus reports a finished fill by index, the buffer and every miss slot linked to it are freed together, and the freed slots' tags are reported on a completion vector. Loads that hit keep flowing at all times. A miss is refused with a same-cycle stall only when the miss queue has no free slot, or when every fill buffer is busy and none holds the missed line.

Top module: `ld_miss_tracker`

## Requirements
- R1: After reset there is no bus request, no completion bit set and no stall.
- R2: A miss accepted at a clock edge to a line held by no fill buffer takes the lowest free fill buffer, and from the next cycle a bus request shows that line with that buffer's index.
- R3: A miss to a line that a fill buffer already holds (whether its request has left or not) is accepted without any further bus request.
- R4: A lookup that hits never stalls and takes no miss slot, also while the miss queue is full.
- R5: A miss arriving while all miss slots are taken raises the stall in the same cycle and is not accepted.
- R6: A miss to a line held by no fill buffer raises the stall while every fill buffer is busy; a miss matching a held line is accepted in that state as long as a miss slot is free.
- R7: Bus requests leave in the order their fill buffers were taken, and a request not taken (ready low) keeps its line and index unchanged.
- R8: A fill reported at a clock edge with a buffer index frees that buffer and every miss slot linked to it; in the next cycle bit s of the completion vector is set for each freed slot s with its tag in field s of the tag bus, and the vector clears one cycle later.
- R9: Miss slots take the lowest free index, and slots and buffers freed by a fill can be taken again from the next cycle, so a new miss to the just-filled line issues a fresh request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_valid | input | 1 | A lookup is presented this cycle |
| lkp_hit | input | 1 | The lookup hit the cache |
| lkp_line | input | LINE_W | Line address of the lookup (address bits above the byte offset) |
| lkp_tag | input | TAG_W | Destination tag of the load |
| lkp_stall | output | 1 | The presented miss is refused this cycle |
| rd_req_valid | output | 1 | A line read request is offered to the bus |
| rd_req_ready | input | 1 | The bus takes the request this cycle |
| rd_req_line | output | LINE_W | Line address to read |
| rd_req_id | output | FB_IDX_W | Fill buffer index of the request |
| fill_valid | input | 1 | The bus finished a line fill this cycle |
| fill_id | input | FB_IDX_W | Fill buffer index of the finished fill |
| done_vld | output | LMQ_DEPTH | One bit per miss slot released by the last fill |
| done_tags | output | LMQ_DEPTH*TAG_W | Tags of the released slots, field s for slot s |

## Verification
The stall is combinational and is sampled one nanosecond after inputs change at the falling edge, before the edge that would accept the miss. A bus request and a completion vector each come from one register stage, so they are sampled in the cycle after the accepting edge or the fill edge, and the completion vector is sampled once more a cycle later to prove it lasts a single cycle. Request order is checked by holding ready low while buffers fill, then raising it and reading one request per cycle.

// File: rtl/lmt_pkg.sv
package lmt_pkg;
  localparam int WORD_BYTES = 4;
  localparam int LINE_WORDS = 8;
  localparam int LINE_BYTES = WORD_BYTES * LINE_WORDS;
  localparam int LINE_OFS   = $clog2(LINE_BYTES);

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lmt_fb_table.sv
module lmt_fb_table #(
  parameter int NFB    = 2,
  parameter int LINE_W = 27,
  parameter int IDX_W  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] probe_line,
  input  logic              alloc_en,
  input  logic              rel_en,
  input  logic [IDX_W-1:0]  rel_id,
  input  logic [IDX_W-1:0]  rd_id,
  output logic [LINE_W-1:0] rd_line,
  output logic              match_any,
  output logic [IDX_W-1:0]  match_id,
  output logic              full,
  output logic [IDX_W-1:0]  free_id
);
  logic [NFB-1:0]    busy_q;
  logic [LINE_W-1:0] line_mem [NFB];
  logic [NFB-1:0]    match_vec;

  // parallel compare; an entry being released this cycle is not a match
  always_comb begin
    match_vec = '0;
    match_id  = '0;
    for (int i = 0; i < NFB; i++) begin
      if (busy_q[i] && !(rel_en && rel_id == IDX_W'(i)) &&
          line_mem[i] == probe_line)
        match_vec[i] = 1'b1;
    end
    for (int i = 0; i < NFB; i++)
      if (match_vec[i]) match_id = match_id | IDX_W'(i);
    match_any = |match_vec;
  end

  always_comb begin
    free_id = '0;
    for (int i = NFB - 1; i >= 0; i--)
      if (!busy_q[i]) free_id = IDX_W'(i);
    full = &busy_q;
  end

  assign rd_line = line_mem[rd_id];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
    end else begin
      if (rel_en)   busy_q[rel_id]  <= 1'b0;
      if (alloc_en) busy_q[free_id] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) line_mem[free_id] <= probe_line;
  end
endmodule

// File: rtl/lmt_req_fifo.sv
module lmt_req_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         not_empty,
  output logic [W-1:0] head
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign not_empty = (cnt != '0);
  assign head      = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      if (push && !pop)      cnt <= cnt + CNT_W'(1);
      else if (pop && !push) cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/lmt_slots.sv
module lmt_slots #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 6,
  parameter int IDX_W = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   alloc_en,
  input  logic [TAG_W-1:0]       alloc_tag,
  input  logic [IDX_W-1:0]       alloc_fb,
  input  logic                   rel_en,
  input  logic [IDX_W-1:0]       rel_fb,
  output logic                   full,
  output logic [DEPTH-1:0]       done_vld,
  output logic [DEPTH*TAG_W-1:0] done_tags
);
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] used_q;
  logic [TAG_W-1:0] tag_q  [DEPTH];
  logic [IDX_W-1:0] link_q [DEPTH];
  logic [DEPTH-1:0] rel_hit;
  logic [SLOT_W-1:0] free_slot;

  always_comb begin
    free_slot = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!used_q[i]) free_slot = SLOT_W'(i);
    full = &used_q;
  end

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      assign rel_hit[s] = used_q[s] && rel_en && (link_q[s] == rel_fb);

      always_ff @(posedge clk) begin
        if (rst) begin
          used_q[s]                   <= 1'b0;
          done_vld[s]                 <= 1'b0;
          done_tags[s*TAG_W +: TAG_W] <= '0;
        end else begin
          done_vld[s]                 <= rel_hit[s];
          done_tags[s*TAG_W +: TAG_W] <= rel_hit[s] ? tag_q[s] : '0;
          if (rel_hit[s])
            used_q[s] <= 1'b0;
          else if (alloc_en && free_slot == SLOT_W'(s))
            used_q[s] <= 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (alloc_en && free_slot == SLOT_W'(s)) begin
          tag_q[s]  <= alloc_tag;
          link_q[s] <= alloc_fb;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ld_miss_tracker.sv
module ld_miss_tracker #(
  parameter int ADDR_W    = 32,
  parameter int TAG_W     = 6,
  parameter int LMQ_DEPTH = 4,
  parameter int FB_COUNT  = 2,
  localparam int LINE_W   = ADDR_W - lmt_pkg::LINE_OFS,
  localparam int FB_IDX_W = lmt_pkg::idx_width(FB_COUNT)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       lkp_valid,
  input  logic                       lkp_hit,
  input  logic [LINE_W-1:0]          lkp_line,
  input  logic [TAG_W-1:0]           lkp_tag,
  output logic                       lkp_stall,
  output logic                       rd_req_valid,
  input  logic                       rd_req_ready,
  output logic [LINE_W-1:0]          rd_req_line,
  output logic [FB_IDX_W-1:0]        rd_req_id,
  input  logic                       fill_valid,
  input  logic [FB_IDX_W-1:0]        fill_id,
  output logic [LMQ_DEPTH-1:0]       done_vld,
  output logic [LMQ_DEPTH*TAG_W-1:0] done_tags
);
  logic                is_miss, accept, fb_alloc;
  logic                fb_match, fb_full, lmq_full;
  logic [FB_IDX_W-1:0] match_id, free_id, link_id;

  assign is_miss   = lkp_valid && !lkp_hit;
  assign lkp_stall = is_miss && (lmq_full || (fb_full && !fb_match));
  assign accept    = is_miss && !lkp_stall;
  assign fb_alloc  = accept && !fb_match;
  assign link_id   = fb_match ? match_id : free_id;

  lmt_fb_table #(.NFB(FB_COUNT), .LINE_W(LINE_W), .IDX_W(FB_IDX_W)) fb_i (
    .clk        (clk),
    .rst        (rst),
    .probe_line (lkp_line),
    .alloc_en   (fb_alloc),
    .rel_en     (fill_valid),
    .rel_id     (fill_id),
    .rd_id      (rd_req_id),
    .rd_line    (rd_req_line),
    .match_any  (fb_match),
    .match_id   (match_id),
    .full       (fb_full),
    .free_id    (free_id)
  );

  lmt_req_fifo #(.DEPTH(FB_COUNT), .W(FB_IDX_W)) req_i (
    .clk       (clk),
    .rst       (rst),
    .push      (fb_alloc),
    .push_data (free_id),
    .pop       (rd_req_valid && rd_req_ready),
    .not_empty (rd_req_valid),
    .head      (rd_req_id)
  );

  lmt_slots #(.DEPTH(LMQ_DEPTH), .TAG_W(TAG_W), .IDX_W(FB_IDX_W)) lmq_i (
    .clk       (clk),
    .rst       (rst),
    .alloc_en  (accept),
    .alloc_tag (lkp_tag),
    .alloc_fb  (link_id),
    .rel_en    (fill_valid),
    .rel_fb    (fill_id),
    .full      (lmq_full),
    .done_vld  (done_vld),
    .done_tags (done_tags)
  );
endmodule

// File: rtl/lmt_checker.sv
module lmt_checker #(
  parameter int LINE_W    = 27,
  parameter int FB_IDX_W  = 1,
  parameter int LMQ_DEPTH = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 lkp_valid,
  input logic                 lkp_hit,
  input logic                 lkp_stall,
  input logic                 rd_req_valid,
  input logic                 rd_req_ready,
  input logic [LINE_W-1:0]    rd_req_line,
  input logic [FB_IDX_W-1:0]  rd_req_id,
  input logic                 fill_valid,
  input logic [LMQ_DEPTH-1:0] done_vld,
  input logic                 fb_alloc
);
  AST_NEW_LINE_REQUESTS: assert property (@(posedge clk) disable iff (rst)
    fb_alloc |=> rd_req_valid); // R2

  AST_HIT_NEVER_STALLS: assert property (@(posedge clk) disable iff (rst)
    (lkp_valid && lkp_hit) |-> !lkp_stall); // R4

  AST_STALL_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    lkp_stall |-> (lkp_valid && !lkp_hit)); // R5

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (rd_req_valid && !rd_req_ready) |=>
      (rd_req_valid && $stable(rd_req_line) && $stable(rd_req_id))); // R7

  AST_DONE_NEEDS_FILL: assert property (@(posedge clk) disable iff (rst)
    (done_vld != '0) |-> $past(fill_valid)); // R8
endmodule

bind ld_miss_tracker lmt_checker #(
  .LINE_W(LINE_W), .FB_IDX_W(FB_IDX_W), .LMQ_DEPTH(LMQ_DEPTH)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .lkp_valid    (lkp_valid),
  .lkp_hit      (lkp_hit),
  .lkp_stall    (lkp_stall),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_line  (rd_req_line),
  .rd_req_id    (rd_req_id),
  .fill_valid   (fill_valid),
  .done_vld     (done_vld),
  .fb_alloc     (fb_alloc)
);

// File: tb/ld_miss_tracker_tb_top.sv
module ld_miss_tracker_tb_top;
  localparam int ADDR_W = 32;
  localparam int TAG_W  = 6;
  localparam int DEPTH  = 4;
  localparam int NFB    = 2;
  localparam int LINE_W = ADDR_W - 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lkp_valid = 1'b0, lkp_hit = 1'b0;
  logic [LINE_W-1:0] lkp_line = '0;
  logic [TAG_W-1:0]  lkp_tag = '0;
  logic lkp_stall, rd_req_valid;
  logic rd_req_ready = 1'b0;
  logic [LINE_W-1:0] rd_req_line;
  logic [0:0] rd_req_id;
  logic fill_valid = 1'b0;
  logic [0:0] fill_id = '0;
  logic [DEPTH-1:0] done_vld;
  logic [DEPTH*TAG_W-1:0] done_tags;

  int vectors = 0;
  int errors  = 0;

  localparam logic [31:0] ADDR_A = 32'h0000_1040;
  localparam logic [31:0] ADDR_B = 32'h0000_2000;
  localparam logic [31:0] ADDR_C = 32'h0000_3000;

  always #4 clk = ~clk;

  ld_miss_tracker #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .LMQ_DEPTH(DEPTH), .FB_COUNT(NFB)) dut_i (
    .clk(clk), .rst(rst), .lkp_valid(lkp_valid), .lkp_hit(lkp_hit),
    .lkp_line(lkp_line), .lkp_tag(lkp_tag), .lkp_stall(lkp_stall),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_line(rd_req_line), .rd_req_id(rd_req_id),
    .fill_valid(fill_valid), .fill_id(fill_id),
    .done_vld(done_vld), .done_tags(done_tags)
  );

  function automatic logic [LINE_W-1:0] line_of(input logic [31:0] a);
    return a[31:5];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // present one lookup for one edge, checking the same-cycle stall
  task automatic lookup(input string req, input logic hit, input logic [31:0] addr,
                        input logic [TAG_W-1:0] tag, input logic exp_stall);
    @(negedge clk);
    lkp_valid = 1'b1; lkp_hit = hit; lkp_line = line_of(addr); lkp_tag = tag;
    #1 chk(req, "stall", 64'(lkp_stall), 64'(exp_stall));
    @(negedge clk);
    lkp_valid = 1'b0; lkp_hit = 1'b0;
  endtask

  task automatic check_req(input string req, input logic exp_v,
                           input logic [31:0] addr, input logic exp_id);
    #1 chk(req, "req_valid", 64'(rd_req_valid), 64'(exp_v));
    if (exp_v) begin
      chk(req, "req_line", 64'(rd_req_line), 64'(line_of(addr)));
      chk(req, "req_id", 64'(rd_req_id), 64'(exp_id));
    end
  endtask

  task automatic fill_and_check(input string req, input logic id,
                                input logic [DEPTH-1:0] exp_mask,
                                input logic [DEPTH*TAG_W-1:0] exp_tags);
    @(negedge clk);
    fill_valid = 1'b1; fill_id = id;
    @(negedge clk);
    fill_valid = 1'b0;
    #1 chk(req, "done_vld", 64'(done_vld), 64'(exp_mask));
    chk(req, "done_tags", 64'(done_tags), 64'(exp_tags));
    @(negedge clk);
    #1 chk(req, "done_vld clears", 64'(done_vld), 64'(0));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1 chk("R1", "req_valid", 64'(rd_req_valid), 64'(0));
    chk("R1", "done_vld", 64'(done_vld), 64'(0));
    chk("R1", "stall", 64'(lkp_stall), 64'(0));
  endtask

  task automatic t_first_miss();
    lookup("R2", 1'b0, ADDR_A, 6'd1, 1'b0);
    check_req("R2", 1'b1, ADDR_A, 1'b0);
  endtask

  task automatic t_merge_and_hit();
    lookup("R3", 1'b0, ADDR_A + 32'd4, 6'd2, 1'b0);
    check_req("R3", 1'b1, ADDR_A, 1'b0);
    lookup("R4", 1'b1, ADDR_C, 6'd9, 1'b0);
  endtask

  task automatic t_fill_buffers_full();
    lookup("R2", 1'b0, ADDR_B, 6'd3, 1'b0);
    check_req("R7", 1'b1, ADDR_A, 1'b0);   // ready low: head unchanged
    lookup("R6", 1'b0, ADDR_C, 6'd4, 1'b1);
    lookup("R6", 1'b0, ADDR_A + 32'd8, 6'd5, 1'b0);
  endtask

  task automatic t_queue_full();
    lookup("R5", 1'b0, ADDR_B, 6'd6, 1'b1);
    lookup("R4", 1'b1, ADDR_C, 6'd10, 1'b0);
  endtask

  task automatic t_issue_order();
    @(negedge clk);
    rd_req_ready = 1'b1;
    check_req("R7", 1'b1, ADDR_A, 1'b0);
    @(negedge clk);
    check_req("R7", 1'b1, ADDR_B, 1'b1);
    @(negedge clk);
    check_req("R3", 1'b0, ADDR_A, 1'b0);   // merged misses added no request
    rd_req_ready = 1'b0;
  endtask

  task automatic t_fill_release();
    // slots: 0=tag1,1=tag2 (line A), 2=tag3 (line B), 3=tag5 (line A)
    fill_and_check("R8", 1'b0, 4'b1011, {6'd5, 6'd0, 6'd2, 6'd1});
  endtask

  task automatic t_reuse();
    lookup("R9", 1'b0, ADDR_A, 6'd7, 1'b0);
    check_req("R9", 1'b1, ADDR_A, 1'b0);
    fill_and_check("R8", 1'b1, 4'b0100, {6'd0, 6'd3, 6'd0, 6'd0});
    @(negedge clk);
    rd_req_ready = 1'b1;
    @(negedge clk);
    rd_req_ready = 1'b0;
    fill_and_check("R9", 1'b0, 4'b0001, {6'd0, 6'd0, 6'd0, 6'd7});
  endtask

  initial begin
    t_reset();
    t_first_miss();
    t_merge_and_hit();
    t_fill_buffers_full();
    t_queue_full();
    t_issue_order();
    t_fill_release();
    t_reuse();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule